// File: doc/BRIEF.md
# Raster Frame Store with Scan-Out

This block keeps one frame of 16-bit colour pixels in an on-chip RAM and streams the whole frame out without pause. The stream starts at the top-left pixel, moves left to right along each row and top to bottom through the rows, and wraps back to the top-left pixel after the bottom-right one. A display timing stage consumes the stream. Frame and row boundaries are marked with start-of-frame and end-of-line flags.

A drawing engine may write single pixels at any time, addressed by column and row, with separate red, green and blue fields. A write goes into the frame in the cycle it is presented. It never stalls or delays the scan-out, so a drawing engine and the display can share one frame store with no handshake. The full display is 640 columns by 480 rows. Width and height are parameters, so a small frame can be used in test. The defaults are kept small so that the inferred RAM stays modest at elaboration.

Top module: `pixel_scan_store`

## Requirements
- R1: While `rst_n` is low, `pix_valid`, `pix_sof` and `pix_eol` are all 0.
- R2: From the first clock edge after reset is released, one pixel per cycle is output. Pixel number i is at column i mod WIDTH and row i div WIDTH. After pixel WIDTH*HEIGHT-1 the sequence restarts at pixel 0.
- R3: `pix_sof` is 1 exactly on the cycles that carry pixel (0,0).
- R4: `pix_eol` is 1 exactly on the cycles that carry a pixel in column WIDTH-1.
- R5: An in-range write of colour C at (x,y) is stored at linear address y*WIDTH+x. Later scans of that pixel return C until it is written again.
- R6: A write with x >= WIDTH or y >= HEIGHT changes no pixel of the frame.
- R7: If a write hits the pixel being read in the same cycle, the stream returns the pixel's previous colour. The next scan of that pixel returns the new colour.
- R8: `pix_valid` stays 1 on every cycle after the first output pixel, even when a write is presented on every cycle.
- R9: A stored pixel is packed as red in bits [15:11], green in bits [10:5] and blue in bits [4:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Pixel write request, taken in this cycle |
| wr_x | input | CW | Write column |
| wr_y | input | CW | Write row |
| wr_red | input | 5 | Red field of the write |
| wr_grn | input | 6 | Green field of the write |
| wr_blu | input | 5 | Blue field of the write |
| pix_rgb | output | 16 | Packed colour of the streamed pixel |
| pix_valid | output | 1 | Stream carries a pixel |
| pix_sof | output | 1 | Streamed pixel is (0,0) |
| pix_eol | output | 1 | Streamed pixel is the last of its row |

## Verification
The hardest case to reach from the ports is a write that lands on the very pixel being read on the same edge. The bench tracks the scan position from the stream itself. It presents a write to pixel k in the cycle after pixel k-1 appears, which is the edge on which address k is read. It then expects the old colour in that cycle and the new colour one frame later. Out-of-range writes are chosen so that their unchecked linear address would alias a real pixel, such as column WIDTH of row 0. A missing bound check therefore shows up as a corrupted pixel in the next scan.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef logic [15:0] pix_t;

  // red [15:11], green [10:5], blue [4:0]
  function automatic pix_t fbs_pack(input logic [4:0] r, input logic [5:0] g,
                                    input logic [4:0] b);
    return {r, g, b};
  endfunction

  function automatic int unsigned fbs_lin(input int unsigned x, input int unsigned y,
                                          input int unsigned width);
    return y * width + x;
  endfunction
endpackage

// File: rtl/fbs_wr_gate.sv
module fbs_wr_gate
  import fbs_pkg::*;
#(
  parameter int W  = 64,
  parameter int H  = 48,
  parameter int CW = 10,
  parameter int AW = 12
) (
  input  logic          wr_valid,
  input  logic [CW-1:0] wr_x,
  input  logic [CW-1:0] wr_y,
  input  logic [4:0]    wr_red,
  input  logic [5:0]    wr_grn,
  input  logic [4:0]    wr_blu,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output pix_t          wr_data
);
  logic x_in, y_in;

  assign x_in    = 32'(wr_x) < W;
  assign y_in    = 32'(wr_y) < H;
  assign wr_en   = wr_valid && x_in && y_in;
  assign wr_addr = AW'(fbs_lin(32'(wr_x), 32'(wr_y), W));
  assign wr_data = fbs_pack(wr_red, wr_grn, wr_blu);
endmodule

// File: rtl/fbs_scan_ctr.sv
module fbs_scan_ctr #(
  parameter int W  = 64,
  parameter int H  = 48,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] rd_addr,
  output logic          at_origin,
  output logic          at_row_end
);
  localparam int XW   = (W > 1) ? $clog2(W) : 1;
  localparam int YW   = (H > 1) ? $clog2(H) : 1;
  localparam int LAST = W * H - 1;

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [AW-1:0] addr_q;
  logic          x_wrap, y_wrap;

  assign x_wrap = (x_q == XW'(W - 1));
  assign y_wrap = (y_q == YW'(H - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      addr_q <= '0;
    end else begin
      x_q    <= x_wrap ? '0 : x_q + 1'b1;
      if (x_wrap) y_q <= y_wrap ? '0 : y_q + 1'b1;
      addr_q <= (addr_q == AW'(LAST)) ? '0 : addr_q + 1'b1;
    end
  end

  assign rd_addr    = addr_q;
  assign at_origin  = (x_q == '0) && (y_q == '0);
  assign at_row_end = x_wrap;

  // The linear counter and the column/row counters run independently
  assert_addr_tracks_xy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(addr_q) == 32'(y_q) * W + 32'(x_q));
  assert_col_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    x_wrap |=> (x_q == '0));
  assert_col_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !x_wrap |=> (x_q == $past(x_q) + 1'b1) && (y_q == $past(y_q)));
endmodule

// File: rtl/fbs_ram.sv
module fbs_ram
  import fbs_pkg::*;
#(
  parameter int DEPTH = 3072,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  pix_t          wdata,
  input  logic [AW-1:0] raddr,
  output pix_t          rdata
);
  pix_t mem [DEPTH];

  // one process: read samples the old word on a same-address collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  assert_write_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (32'(waddr) < DEPTH));
  assert_read_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(raddr) < DEPTH);
endmodule

// File: rtl/pixel_scan_store.sv
module pixel_scan_store
  import fbs_pkg::*;
#(
  parameter int W  = 64,
  parameter int H  = 48,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [CW-1:0] wr_x,
  input  logic [CW-1:0] wr_y,
  input  logic [4:0]    wr_red,
  input  logic [5:0]    wr_grn,
  input  logic [4:0]    wr_blu,
  output logic [15:0]   pix_rgb,
  output logic          pix_valid,
  output logic          pix_sof,
  output logic          pix_eol
);
  localparam int DEPTH = W * H;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  pix_t          wr_data;
  logic [AW-1:0] rd_addr;
  logic          at_origin, at_row_end;
  pix_t          rd_data;
  logic          valid_q, sof_q, eol_q;

  fbs_wr_gate #(.W(W), .H(H), .CW(CW), .AW(AW)) u_gate (
    .wr_valid(wr_valid), .wr_x(wr_x), .wr_y(wr_y),
    .wr_red(wr_red), .wr_grn(wr_grn), .wr_blu(wr_blu),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fbs_scan_ctr #(.W(W), .H(H), .AW(AW)) u_scan (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr),
    .at_origin(at_origin), .at_row_end(at_row_end)
  );

  fbs_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // flags follow the RAM read by one register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sof_q   <= 1'b0;
      eol_q   <= 1'b0;
    end else begin
      valid_q <= 1'b1;
      sof_q   <= at_origin;
      eol_q   <= at_row_end;
    end
  end

  assign pix_rgb   = rd_data;
  assign pix_valid = valid_q;
  assign pix_sof   = sof_q;
  assign pix_eol   = eol_q;

  assert_stream_unbroken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_valid);
  assert_sof_carries_pixel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof |-> pix_valid && pix_eol == (W == 1));
  assert_eol_carries_pixel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eol |-> pix_valid);

  generate
    if (DEPTH > 1) begin : g_sof_single
      assert_sof_not_repeated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof |=> !pix_sof);
    end
    if (W > 1) begin : g_eol_single
      assert_eol_not_repeated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eol |=> !pix_eol);
    end
  endgenerate
endmodule

// File: tb/pixel_scan_store_tb_top.sv
`timescale 1ns/1ps
module pixel_scan_store_tb_top;
  localparam int W  = 8;
  localparam int H  = 4;
  localparam int CW = 10;
  localparam int N  = W * H;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [CW-1:0] wr_x = '0, wr_y = '0;
  logic [4:0]    wr_red = '0, wr_blu = '0;
  logic [5:0]    wr_grn = '0;
  logic [15:0]   pix_rgb;
  logic          pix_valid, pix_sof, pix_eol;

  pixel_scan_store #(.W(W), .H(H), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_x(wr_x), .wr_y(wr_y),
    .wr_red(wr_red), .wr_grn(wr_grn), .wr_blu(wr_blu),
    .pix_rgb(pix_rgb), .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eol(pix_eol)
  );

  always #5 clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  int    cur = 0;
  bit    started = 0;
  int    col_seen = 0;
  string ptag = "R5";
  logic [15:0] model [N];
  bit          known [N];
  bit          pend_v = 0;
  int          pend_a = 0;
  logic [15:0] pend_c = '0;

  function automatic logic [15:0] colour(int r, int g, int b);
    return 16'(r * 2048 + g * 32 + b);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // a write seen at this edge takes effect for reads after it
  always @(posedge clk) begin
    if (rst_n && wr_valid && int'(wr_x) < W && int'(wr_y) < H) begin
      pend_v = 1;
      pend_a = int'(wr_y) * W + int'(wr_x);
      pend_c = colour(int'(wr_red), int'(wr_grn), int'(wr_blu));
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!pix_valid && !pix_sof && !pix_eol, "R1", "flags in reset",
          {pix_valid, pix_sof, pix_eol}, 0);
    end else begin
      if (!started) begin
        chk(pix_valid, "R2", "first cycle after reset", pix_valid, 1);
        started = 1;
        cur = 0;
      end else begin
        cur = (cur + 1) % N;
      end
      chk(pix_valid, "R8", "valid held", pix_valid, 1);
      chk(pix_sof == (cur == 0), "R3", "sof", pix_sof, cur == 0);
      chk(pix_eol == (cur % W == W - 1), "R4", "eol", pix_eol, cur % W == W - 1);
      if (pend_v && pend_a == cur) begin
        col_seen++;
        if (known[cur]) chk(pix_rgb == model[cur], "R7", "old data on collision",
                            pix_rgb, model[cur]);
      end else if (known[cur]) begin
        chk(pix_rgb == model[cur], ptag, "pixel", pix_rgb, model[cur]);
      end
      if (pend_v) begin
        model[pend_a] = pend_c;
        known[pend_a] = 1;
        pend_v = 0;
      end
    end
  end

  task automatic put(int x, int y, int r, int g, int b);
    @(negedge clk); #1;
    wr_valid = 1; wr_x = CW'(x); wr_y = CW'(y);
    wr_red = 5'(r); wr_grn = 6'(g); wr_blu = 5'(b);
  endtask

  task automatic idle(int cycles);
    @(negedge clk); #1;
    wr_valid = 0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) known[i] = 0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    // R5/R8: fill the frame with writes on every cycle while scanning
    for (int i = 0; i < N; i++) put(i % W, i / W, i, 63 - i, (i * 3) % 32);
    idle(2 * N);
    // R9: single-field colours
    ptag = "R9";
    put(2, 1, 31, 0, 0);
    put(3, 1, 0, 63, 0);
    put(4, 1, 0, 0, 31);
    idle(2 * N);
    chk(model[W + 2] == 16'hF800 && model[W + 3] == 16'h07E0 && model[W + 4] == 16'h001F,
        "R9", "field packing model", model[W + 2], 16'hF800);
    // R6: out-of-range writes, several aliasing real pixels
    ptag = "R6";
    put(W, 0, 1, 1, 1);
    put(W + 1, 1, 2, 2, 2);
    put(0, H, 3, 3, 3);
    put(3, H + 3, 4, 4, 4);
    put(1023, 1023, 31, 63, 31);
    put(1023, 0, 5, 5, 5);
    idle(2 * N);
    // R7: write pixel k on the edge it is read
    ptag = "R7";
    for (int k = 1; k < N; k += 9) begin
      do begin @(negedge clk); #1; end while (cur != k - 1);
      wr_valid = 1; wr_x = CW'(k % W); wr_y = CW'(k / W);
      wr_red = 5'(31 - k); wr_grn = 6'(k); wr_blu = 5'(k + 7);
      @(negedge clk); #1 wr_valid = 0;
    end
    idle(2 * N);
    chk(col_seen >= 3, "R7", "collisions produced", col_seen, 3);
    // R5: rewrite in reverse order, then a second full sweep
    ptag = "R5";
    for (int i = N - 1; i >= 0; i--) put(i % W, i / W, i + 9, (i * 5) % 64, 31 - i % 32);
    idle(2 * N);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule